// File: doc/BRIEF.md
# Two-Level ALU Control with Integer ALU

This block is the execute-stage arithmetic unit of a small load/store processor core together with the logic that decides which operation it performs. Decoding happens in two levels. The 6-bit opcode is first reduced to a 2-bit operation class. That class is then combined with the 6-bit function field into a 3-bit ALU control code. Only register-to-register instructions let the function field choose the operation. Memory instructions always add, to form an address. The compare-and-branch instruction always subtracts, so that the zero flag tells whether its operands are equal.

The ALU works on two `W`-bit operands (32 by default). It produces a result, a zero flag and a signed overflow flag. The control code, result and flags are captured in an output register on each rising clock edge. They therefore describe the inputs that were present at the previous edge. The register file, memory and main control sit outside the block.

Top module: `alu2_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs become `ctl_o` = 3'b010, `result_o` = 0, `zero_o` = 1 and `ovf_o` = 0.
- R2: Opcodes 6'h23 (load) and 6'h2B (store) give `ctl_o` = 3'b010 (add) whatever the function field holds.
- R3: Opcode 6'h04 (branch if equal) gives `ctl_o` = 3'b110 (subtract) whatever the function field holds.
- R4: Opcode 6'h00 (register type) selects by function field: 6'h20 gives 3'b010 add, 6'h22 gives 3'b110 subtract, 6'h24 gives 3'b000 and, 6'h25 gives 3'b001 or, 6'h2A gives 3'b111 set-less-than.
- R5: Any other opcode, and any other function code under opcode 6'h00, gives the add code 3'b010.
- R6: Code 3'b000 returns the bitwise AND of the operands and code 3'b001 returns their bitwise OR.
- R7: Code 3'b010 returns a+b modulo 2^W. Code 3'b110 returns a + ~b + 1 modulo 2^W.
- R8: Code 3'b111 returns 1 in bit 0 when a < b as signed two's complement values, else 0. All higher bits are 0. The comparison stays correct when the subtraction overflows.
- R9: `zero_o` is 1 exactly when `result_o` is all zeros.
- R10: `ovf_o` is the XOR of the carry into and the carry out of the sign bit of the add or subtract. It is 0 for and, or and set-less-than.
- R11: Outputs change only at a rising clock edge. Each output reflects the inputs sampled at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| ctl_o | output | 3 | Registered ALU control code |
| result_o | output | W | Registered ALU result |
| zero_o | output | 1 | Registered all-zero result flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The hardest case to reach is set-less-than when the internal subtraction overflows. There the raw sign of the difference gives the wrong answer, and only the overflow correction yields the right one. Ordinary operands never trigger it. The stimulus therefore pairs the most negative and most positive values with small operands of the opposite sign, under both the set-less-than function code and plain subtract. It repeats this under load, store and branch opcodes with misleading function fields, so that any leak of the function field into forced classes shows up as a wrong control code.

// File: rtl/alu2_pkg.sv
`timescale 1ns/1ps
// alu2_pkg: shared encodings for the two-level ALU decoder and the ALU.
// Assumes 6-bit opcode and function fields; the 3-bit control codes are fixed
// because neighbouring logic decodes them.
package alu2_pkg;

    localparam int OPW = 6;
    localparam int FNW = 6;

    // Operation class produced by the first decode level (2'b11 is unused).
    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    // ALU control code produced by the second decode level.
    typedef enum logic [2:0] {
        CTL_AND = 3'b000,
        CTL_OR  = 3'b001,
        CTL_ADD = 3'b010,
        CTL_SUB = 3'b110,
        CTL_SLT = 3'b111
    } alu_ctl_e;

    localparam logic [OPW-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPW-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPW-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FNW-1:0] FN_ADD = 6'h20;
    localparam logic [FNW-1:0] FN_SUB = 6'h22;
    localparam logic [FNW-1:0] FN_AND = 6'h24;
    localparam logic [FNW-1:0] FN_OR  = 6'h25;
    localparam logic [FNW-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu2_class_dec.sv
`timescale 1ns/1ps
// alu2_class_dec: first decode level. Reduces the opcode to an operation
// class. Memory opcodes map to add, the equality branch to subtract, the
// register-type opcode defers to the function field; anything else adds.
// Purely combinational.
module alu2_class_dec
    import alu2_pkg::*;
(
    input  logic [OPW-1:0] opcode_i,
    output op_class_e      cls_o
);

    // Opcode to class lookup with add as the fallback.
    always_comb begin
        case (opcode_i)
            OPC_LOAD, OPC_STORE: cls_o = CLS_ADD;
            OPC_BEQ:             cls_o = CLS_SUB;
            OPC_RTYPE:           cls_o = CLS_FUNCT;
            default:             cls_o = CLS_ADD;
        endcase
    end

endmodule

// File: rtl/alu2_ctl_dec.sv
`timescale 1ns/1ps
// alu2_ctl_dec: second decode level. Turns the operation class into a 3-bit
// ALU control code. The function field is looked at only for the
// function-field class; unknown function codes and the unused class add.
// Purely combinational.
module alu2_ctl_dec
    import alu2_pkg::*;
(
    input  op_class_e      cls_i,
    input  logic [FNW-1:0] funct_i,
    output alu_ctl_e       ctl_o
);

    alu_ctl_e fn_ctl;

    // Function field to control code for register-type instructions.
    always_comb begin
        case (funct_i)
            FN_ADD:  fn_ctl = CTL_ADD;
            FN_SUB:  fn_ctl = CTL_SUB;
            FN_AND:  fn_ctl = CTL_AND;
            FN_OR:   fn_ctl = CTL_OR;
            FN_SLT:  fn_ctl = CTL_SLT;
            default: fn_ctl = CTL_ADD;
        endcase
    end

    // Class selects a forced code or the function-derived code.
    always_comb begin
        case (cls_i)
            CLS_ADD:   ctl_o = CTL_ADD;
            CLS_SUB:   ctl_o = CTL_SUB;
            CLS_FUNCT: ctl_o = fn_ctl;
            default:   ctl_o = CTL_ADD;
        endcase
    end

endmodule

// File: rtl/alu2_core.sv
`timescale 1ns/1ps
// alu2_core: W-bit integer ALU. Subtraction is addition of the inverted
// second operand with a carry-in of one. The adder is split at the sign bit
// so that the carry into and out of that bit are both visible; their XOR is
// the signed overflow. Set-less-than corrects the difference sign with it.
// Assumes W >= 2. Purely combinational.
module alu2_core
    import alu2_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_ctl_e       ctl_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   result_o,
    output logic           ovf_o
);

    localparam int LOW = W - 1;

    logic         negate;
    logic [W-1:0] b_eff;
    logic [LOW-1:0] low_sum;
    logic         c_sign_in;
    logic         c_sign_out;
    logic         sum_sign;
    logic         ovf_raw;
    logic         less;

    // Operand conditioning: invert b and inject carry for sub and slt.
    always_comb begin
        negate = (ctl_i == CTL_SUB) || (ctl_i == CTL_SLT);
        b_eff  = negate ? ~b_i : b_i;
    end

    // Low part of the adder, yielding the carry into the sign bit.
    always_comb begin
        {c_sign_in, low_sum} = {1'b0, a_i[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                             + {{LOW{1'b0}}, negate};
    end

    // Sign bit stage: sum, carry out, overflow and signed less-than.
    always_comb begin
        sum_sign   = a_i[W-1] ^ b_eff[W-1] ^ c_sign_in;
        c_sign_out = (a_i[W-1] & b_eff[W-1]) | (a_i[W-1] & c_sign_in)
                   | (b_eff[W-1] & c_sign_in);
        ovf_raw    = c_sign_in ^ c_sign_out;
        less       = sum_sign ^ ovf_raw;
    end

    // Result selection and overflow qualification by control code.
    always_comb begin
        case (ctl_i)
            CTL_AND: result_o = a_i & b_i;
            CTL_OR:  result_o = a_i | b_i;
            CTL_SLT: result_o = {{LOW{1'b0}}, less};
            default: result_o = {sum_sign, low_sum};
        endcase
        ovf_o = ((ctl_i == CTL_ADD) || (ctl_i == CTL_SUB)) && ovf_raw;
    end

endmodule

// File: rtl/alu2_unit.sv
`timescale 1ns/1ps
// alu2_unit: top of the two-level ALU control and ALU. Opcode goes to the
// class decoder, class plus function field to the control decoder, control
// code to the ALU. Control code, result, zero and overflow are registered
// once. Synchronous active-low reset clears to the add code, zero result.
module alu2_unit
    import alu2_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode_i,
    input  logic [FNW-1:0] funct_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2:0]     ctl_o,
    output logic [W-1:0]   result_o,
    output logic           zero_o,
    output logic           ovf_o
);

    op_class_e    cls;
    alu_ctl_e     ctl_d;
    logic [W-1:0] res_d;
    logic         ovf_d;

    alu2_class_dec u_cls (
        .opcode_i (opcode_i),
        .cls_o    (cls)
    );

    alu2_ctl_dec u_ctl (
        .cls_i   (cls),
        .funct_i (funct_i),
        .ctl_o   (ctl_d)
    );

    alu2_core #(.W(W)) u_alu (
        .ctl_i    (ctl_d),
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (res_d),
        .ovf_o    (ovf_d)
    );

    // Output stage: capture control code, result and flags each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o    <= CTL_ADD;
            result_o <= '0;
            zero_o   <= 1'b1;
            ovf_o    <= 1'b0;
        end else begin
            ctl_o    <= ctl_d;
            result_o <= res_d;
            zero_o   <= (res_d == '0);
            ovf_o    <= ovf_d;
        end
    end

endmodule

// alu2_unit_chk: temporal checks on the ports of alu2_unit. Assumes the
// synchronous reset has been low for at least one edge at time zero.
module alu2_unit_chk
    import alu2_pkg::*;
#(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] opcode_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic [2:0]     ctl_o,
    input logic [W-1:0]   result_o,
    input logic           zero_o,
    input logic           ovf_o
);

    logic live;

    // Marks edges whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (ctl_o == CTL_ADD) && (result_o == '0) && zero_o && !ovf_o);

    a_r2_mem_forces_add: assert property (@(posedge clk) disable iff (!rst_n)
        live && (($past(opcode_i) == OPC_LOAD) || ($past(opcode_i) == OPC_STORE))
        |-> ctl_o == CTL_ADD);

    a_r3_branch_subtracts: assert property (@(posedge clk) disable iff (!rst_n)
        live && ($past(opcode_i) == OPC_BEQ)
        |-> (ctl_o == CTL_SUB) && (result_o == $past(a_i) - $past(b_i)));

    a_r7_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        live && (ctl_o == CTL_ADD) |-> result_o == $past(a_i) + $past(b_i));

    a_r8_slt_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        live && (ctl_o == CTL_SLT) |-> result_o[W-1:1] == '0);

    a_r9_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> zero_o == (result_o == '0));

    a_r10_no_ovf_logic: assert property (@(posedge clk) disable iff (!rst_n)
        live && ((ctl_o == CTL_AND) || (ctl_o == CTL_OR) || (ctl_o == CTL_SLT))
        |-> !ovf_o);

    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        live && $stable(opcode_i) && $stable(a_i) && $stable(b_i)
        && ($past(opcode_i) == OPC_BEQ) |=> $stable(result_o));

endmodule

bind alu2_unit alu2_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu2_unit.sv
`timescale 1ns/1ps
module sim_alu2_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [5:0]  funct_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [2:0]  ctl_o;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [2:0]  e_ctl;
    logic [31:0] e_res;
    logic        e_zero;
    logic        e_ovf;
    string       t_ctl;
    string       t_res;

    always #4 clk = ~clk;

    alu2_unit u0 (.*);

    // Behavioural reference: decode and arithmetic from the requirements.
    task automatic model(input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b);
        longint sa;
        longint sb;
        longint s;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (op == 6'h23 || op == 6'h2B) begin e_ctl = 3'b010; t_ctl = "R2"; end
        else if (op == 6'h04)          begin e_ctl = 3'b110; t_ctl = "R3"; end
        else if (op == 6'h00 && fn == 6'h20) begin e_ctl = 3'b010; t_ctl = "R4"; end
        else if (op == 6'h00 && fn == 6'h22) begin e_ctl = 3'b110; t_ctl = "R4"; end
        else if (op == 6'h00 && fn == 6'h24) begin e_ctl = 3'b000; t_ctl = "R4"; end
        else if (op == 6'h00 && fn == 6'h25) begin e_ctl = 3'b001; t_ctl = "R4"; end
        else if (op == 6'h00 && fn == 6'h2A) begin e_ctl = 3'b111; t_ctl = "R4"; end
        else begin e_ctl = 3'b010; t_ctl = "R5"; end
        e_ovf = 1'b0;
        case (e_ctl)
            3'b000: begin e_res = a & b; t_res = "R6"; end
            3'b001: begin e_res = a | b; t_res = "R6"; end
            3'b111: begin e_res = (sa < sb) ? 32'd1 : 32'd0; t_res = "R8"; end
            3'b110: begin
                e_res = a - b; t_res = "R7"; s = sa - sb;
                e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            default: begin
                e_res = a + b; t_res = "R7"; s = sa + sb;
                e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
        endcase
        e_zero = (e_res == 32'd0);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One vector: drive after a falling edge, check before the next one.
    task automatic step(input logic [5:0] op, input logic [5:0] fn,
                        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] prev_res;
        prev_res = result_o;
        opcode_i = op; funct_i = fn; a_i = a; b_i = b;
        #1;
        chk("R11", "held before edge", result_o, prev_res);
        model(op, fn, a, b);
        @(negedge clk);
        chk(t_ctl, "ctl", {29'd0, ctl_o}, {29'd0, e_ctl});
        chk(t_res, "result", result_o, e_res);
        chk("R9", "zero", {31'd0, zero_o}, {31'd0, e_zero});
        chk("R10", "ovf", {31'd0, ovf_o}, {31'd0, e_ovf});
    endtask

    task automatic check_reset();
        chk("R1", "reset ctl", {29'd0, ctl_o}, 32'd2);
        chk("R1", "reset result", result_o, 32'd0);
        chk("R1", "reset zero", {31'd0, zero_o}, 32'd1);
        chk("R1", "reset ovf", {31'd0, ovf_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [8];
        logic [5:0] fns [6];
        ops = '{6'h00, 6'h00, 6'h00, 6'h23, 6'h2B, 6'h04, 6'h3F, 6'h11};
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h07};
        repeat (2) @(negedge clk);
        check_reset();
        // Inputs present during reset must not leak out (R1).
        opcode_i = 6'h00; funct_i = 6'h24; a_i = 32'hFFFF_0000; b_i = 32'h00FF_FF00;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        // R2: memory opcodes add, function field misleading.
        step(6'h23, 6'h2A, 32'd5, 32'd3);
        step(6'h2B, 6'h22, 32'hFFFF_FFFC, 32'd4);
        // R3: branch subtracts; equal and unequal operands.
        step(6'h04, 6'h24, 32'h1234_5678, 32'h1234_5678);
        step(6'h04, 6'h25, 32'd10, 32'd11);
        // R4 / R6 / R7 register-type functions.
        step(6'h00, 6'h20, 32'h7FFF_FFFF, 32'd1);
        step(6'h00, 6'h22, 32'h8000_0000, 32'd1);
        step(6'h00, 6'h24, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        step(6'h00, 6'h25, 32'hF0F0_0000, 32'h0000_0F0F);
        step(6'h00, 6'h25, 32'd0, 32'd0);
        // R8: set-less-than including overflowing differences.
        step(6'h00, 6'h2A, 32'h8000_0000, 32'd1);
        step(6'h00, 6'h2A, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        step(6'h00, 6'h2A, 32'hFFFF_FFFF, 32'd0);
        step(6'h00, 6'h2A, 32'd9, 32'd9);
        // R10: overflow on add of negatives and on subtract.
        step(6'h00, 6'h20, 32'h8000_0000, 32'h8000_0000);
        step(6'h04, 6'h00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R5: unknown opcode and unknown function code.
        step(6'h3F, 6'h22, 32'd100, 32'd23);
        step(6'h00, 6'h00, 32'd7, 32'hFFFF_FFF9);
        // Mixed pseudo-random vectors.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = (i % 5 == 0) ? ra : $urandom;
            if (i % 7 == 0) ra = {ra[31], 31'h7FFF_FFFF & {31{ra[31]}} ^ {31{ra[31]}}};
            step(ops[i % 8], (i % 3 == 0) ? 6'($urandom) : fns[(i / 8) % 6], ra, rb);
        end
        // R1 again in mid-run.
        opcode_i = 6'h00; funct_i = 6'h20; a_i = 32'd1; b_i = 32'd1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        step(6'h00, 6'h22, 32'd3, 32'd5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule